// File: doc/BRIEF.md
# Processor Exception Entry and Reset Sequencer

This block holds the supervisor status fields of a small processor core and steers every entry into an exception. It drives the supervisor, trace and master bits, the 3-bit interrupt mask, the vector base register and a small set of memory-enable bits. For each exception it raises a vector-fetch request whose address is the vector base plus four times the vector number. The core's decode logic reports faults as one-cycle pulses. An interrupt source presents a request with a level and an optional pre-supplied vector.

A fault that arrives while an exception is still being entered is treated as fatal. The reset fetch, an interrupt acknowledge wait and a vector fetch all count as exception entry. A configuration bit chooses what happens next. The sequencer either issues a one-cycle illegal-address reset request and re-initialises itself, or it locks into a halted state that only the reset input clears. A second configuration bit chooses where an interrupt's vector comes from. It is either fetched through an acknowledge handshake or taken from the vector number that came with the request. Software-visible writes to the status, base and memory-enable registers arrive on simple write strobes. These writes take effect only while ordinary instructions are running.

Top module: `exc_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, sr_s=1, sr_t=0, sr_m=0, sr_ipl=3'b111, vbr=0, mem_en=0, halted=0, and the block requests the vector-0 fetch at address 0 (vf_req=1, vf_vector=0).
- R2: The reset fetch finishes on the clock edge that samples `fetch_ack` high. After that edge the block is running, and vf_req is 0 until the next exception.
- R3: In the running state, faults are taken with priority address error (vector 3) > illegal instruction (vector 4) > unsupported instruction (vector 61) > interrupt. The fetch that follows drives vf_vector and vf_addr = vbr + 4*vf_vector.
- R4: Any exception entry sets sr_s=1 and clears sr_t. A fault entry leaves sr_m and sr_ipl unchanged.
- R5: An interrupt request is taken only when irq_level > sr_ipl or irq_level = 7. When it is taken, sr_ipl becomes irq_level on the same edge. A request that is not taken changes nothing.
- R6: With cfg_iack_en=1, a taken interrupt raises iack_req with iack_level equal to the level, waits for iack_ack, and fetches iack_vec. With cfg_iack_en=0 it fetches irq_vec directly.
- R7: exc_done is high for exactly one cycle after each accepted `fetch_ack`. A fault after that point is an ordinary fault and raises no reset request.
- R8: With cfg_fof_halt=0, a fault during the reset fetch, the acknowledge wait or a vector fetch produces a one-cycle addr_rst_req. On the same edge, all R1 reset values are reloaded and the vector-0 fetch is requested again.
- R9: With cfg_fof_halt=1, such a fault sets halted=1 and drops vf_req and iack_req. All other inputs are then ignored until `rst_n` goes low.
- R10: sr_we writes {s,t,m,ipl} from sr_wdata bits [5],[4],[3],[2:0]. vbr_we and mem_we load vbr and mem_en. These writes take effect only in the running state, and not in a cycle where an exception is taken.
- R11: `rst_n` is asynchronous. Driving it low during any exception entry or halt restores the R1 values at once, and the interrupted work is not resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fof_halt | input | 1 | 1: halt on fault-on-fault; 0: request illegal-address reset |
| cfg_iack_en | input | 1 | 1: fetch interrupt vector via acknowledge cycle |
| flt_addr | input | 1 | Address error fault pulse |
| flt_illegal | input | 1 | Illegal instruction fault pulse |
| flt_unsup | input | 1 | Unsupported instruction fault pulse |
| irq_req | input | 1 | Interrupt request |
| irq_level | input | 3 | Interrupt request level |
| irq_vec | input | VEC_W | Pre-supplied interrupt vector number |
| iack_ack | input | 1 | Acknowledge cycle complete |
| iack_vec | input | VEC_W | Vector returned by acknowledge cycle |
| fetch_ack | input | 1 | Vector fetch complete |
| sr_we | input | 1 | Status register write strobe |
| sr_wdata | input | 6 | Status write data {s,t,m,ipl[2:0]} |
| vbr_we | input | 1 | Vector base write strobe |
| vbr_wdata | input | ADDR_W | Vector base write data |
| mem_we | input | 1 | Memory-enable write strobe |
| mem_wdata | input | MEM_W | Memory-enable write data |
| sr_s | output | 1 | Supervisor bit |
| sr_t | output | 1 | Trace bit |
| sr_m | output | 1 | Master bit |
| sr_ipl | output | 3 | Interrupt mask |
| vbr | output | ADDR_W | Vector base register |
| mem_en | output | MEM_W | Memory-enable bits |
| vf_req | output | 1 | Vector fetch request |
| vf_vector | output | VEC_W | Vector number being fetched |
| vf_addr | output | ADDR_W | Vector fetch address |
| iack_req | output | 1 | Interrupt acknowledge request |
| iack_level | output | 3 | Level being acknowledged |
| exc_done | output | 1 | One-cycle end-of-entry pulse |
| addr_rst_req | output | 1 | Illegal-address reset request pulse |
| halted | output | 1 | Halted until reset |

## Verification
The bench sweeps every non-empty combination of the three fault pulses, with and without a competing level-7 interrupt, across several base addresses. A wrong priority encoder would fetch the wrong vector, and a carry bug in the address adder would misplace the fetch. It sweeps all 64 mask/level pairs in both vector-source modes, which catches an off-by-one at the mask boundary, a level-7 request that is wrongly refused, or a mask that is not raised. It raises a second fault inside the reset fetch, the acknowledge wait and a vector fetch. A design that missed the entry window would silently restart instead of resetting or halting. It also pokes a halted block and issues writes during entry, which shows up any state that leaks through after halt or during entry.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int IPL_W = 3;
    localparam int SRW_W = IPL_W + 3;

    localparam int VECNUM_RESET   = 0;
    localparam int VECNUM_ADDRERR = 3;
    localparam int VECNUM_ILLEGAL = 4;
    localparam int VECNUM_UNSUP   = 61;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_RUN   = 3'd1,
        ST_ENTRY = 3'd2,
        ST_IACK  = 3'd3,
        ST_HALT  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/exc_fault_pri.sv
module exc_fault_pri #(
    parameter int VEC_W = 8
) (
    input  logic             flt_addr,
    input  logic             flt_illegal,
    input  logic             flt_unsup,
    output logic             any_fault,
    output logic [VEC_W-1:0] fault_vec
);
    import exc_seq_pkg::*;

    always_comb begin
        any_fault = flt_addr | flt_illegal | flt_unsup;
        if (flt_addr) begin
            fault_vec = VEC_W'(VECNUM_ADDRERR);
        end else if (flt_illegal) begin
            fault_vec = VEC_W'(VECNUM_ILLEGAL);
        end else begin
            fault_vec = VEC_W'(VECNUM_UNSUP);
        end
    end
endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
    parameter int LVL_W = 3
) (
    input  logic             req,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] mask,
    output logic             take
);
    localparam logic [LVL_W-1:0] TOP_LVL = '1;

    always_comb begin
        take = req && ((level > mask) || (level == TOP_LVL));
    end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - VEC_W - 2;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = {{PAD_W{1'b0}}, vec, 2'b00};
        addr   = base + offset;
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq #(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8,
    parameter int MEM_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_fof_halt,
    input  logic                           cfg_iack_en,
    input  logic                           flt_addr,
    input  logic                           flt_illegal,
    input  logic                           flt_unsup,
    input  logic                           irq_req,
    input  logic [exc_seq_pkg::IPL_W-1:0]  irq_level,
    input  logic [VEC_W-1:0]               irq_vec,
    input  logic                           iack_ack,
    input  logic [VEC_W-1:0]               iack_vec,
    input  logic                           fetch_ack,
    input  logic                           sr_we,
    input  logic [exc_seq_pkg::SRW_W-1:0]  sr_wdata,
    input  logic                           vbr_we,
    input  logic [ADDR_W-1:0]              vbr_wdata,
    input  logic                           mem_we,
    input  logic [MEM_W-1:0]               mem_wdata,
    output logic                           sr_s,
    output logic                           sr_t,
    output logic                           sr_m,
    output logic [exc_seq_pkg::IPL_W-1:0]  sr_ipl,
    output logic [ADDR_W-1:0]              vbr,
    output logic [MEM_W-1:0]               mem_en,
    output logic                           vf_req,
    output logic [VEC_W-1:0]               vf_vector,
    output logic [ADDR_W-1:0]              vf_addr,
    output logic                           iack_req,
    output logic [exc_seq_pkg::IPL_W-1:0]  iack_level,
    output logic                           exc_done,
    output logic                           addr_rst_req,
    output logic                           halted
);
    import exc_seq_pkg::*;

    typedef struct packed {
        seq_state_e        st;
        logic              s;
        logic              t;
        logic              m;
        logic [IPL_W-1:0]  ipl;
        logic [ADDR_W-1:0] vbr;
        logic [MEM_W-1:0]  mem;
        logic [VEC_W-1:0]  vec;
        logic [IPL_W-1:0]  lvl;
        logic              done;
        logic              arr;
    } seq_regs_t;

    localparam seq_regs_t RESET_VALS = '{
        st:   ST_RESET,
        s:    1'b1,
        t:    1'b0,
        m:    1'b0,
        ipl:  '1,
        vbr:  '0,
        mem:  '0,
        vec:  VEC_W'(VECNUM_RESET),
        lvl:  '0,
        done: 1'b0,
        arr:  1'b0
    };

    seq_regs_t regs_q, regs_d;

    logic             any_fault;
    logic [VEC_W-1:0] fault_vec;
    logic             irq_take;

    exc_fault_pri #(.VEC_W(VEC_W)) u_fault_pri (
        .flt_addr    (flt_addr),
        .flt_illegal (flt_illegal),
        .flt_unsup   (flt_unsup),
        .any_fault   (any_fault),
        .fault_vec   (fault_vec)
    );

    exc_irq_gate #(.LVL_W(IPL_W)) u_irq_gate (
        .req   (irq_req),
        .level (irq_level),
        .mask  (regs_q.ipl),
        .take  (irq_take)
    );

    exc_vec_addr #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_vec_addr (
        .base (regs_q.vbr),
        .vec  (regs_q.vec),
        .addr (vf_addr)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        regs_d.arr  = 1'b0;

        unique case (regs_q.st)
            ST_RUN: begin
                if (any_fault) begin
                    regs_d.s   = 1'b1;
                    regs_d.t   = 1'b0;
                    regs_d.vec = fault_vec;
                    regs_d.st  = ST_ENTRY;
                end else if (irq_take) begin
                    regs_d.s   = 1'b1;
                    regs_d.t   = 1'b0;
                    regs_d.ipl = irq_level;
                    regs_d.lvl = irq_level;
                    if (cfg_iack_en) begin
                        regs_d.st = ST_IACK;
                    end else begin
                        regs_d.vec = irq_vec;
                        regs_d.st  = ST_ENTRY;
                    end
                end else begin
                    if (sr_we) begin
                        regs_d.s   = sr_wdata[IPL_W+2];
                        regs_d.t   = sr_wdata[IPL_W+1];
                        regs_d.m   = sr_wdata[IPL_W];
                        regs_d.ipl = sr_wdata[IPL_W-1:0];
                    end
                    if (vbr_we) begin
                        regs_d.vbr = vbr_wdata;
                    end
                    if (mem_we) begin
                        regs_d.mem = mem_wdata;
                    end
                end
            end
            ST_RESET, ST_ENTRY, ST_IACK: begin
                if (any_fault) begin
                    if (cfg_fof_halt) begin
                        regs_d.st = ST_HALT;
                    end else begin
                        regs_d     = RESET_VALS;
                        regs_d.arr = 1'b1;
                    end
                end else if (regs_q.st == ST_IACK) begin
                    if (iack_ack) begin
                        regs_d.vec = iack_vec;
                        regs_d.st  = ST_ENTRY;
                    end
                end else if (fetch_ack) begin
                    regs_d.done = 1'b1;
                    regs_d.st   = ST_RUN;
                end
            end
            ST_HALT: begin
                regs_d = regs_q;
            end
            default: begin
                regs_d = RESET_VALS;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= RESET_VALS;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        sr_s         = regs_q.s;
        sr_t         = regs_q.t;
        sr_m         = regs_q.m;
        sr_ipl       = regs_q.ipl;
        vbr          = regs_q.vbr;
        mem_en       = regs_q.mem;
        vf_req       = (regs_q.st == ST_RESET) || (regs_q.st == ST_ENTRY);
        vf_vector    = regs_q.vec;
        iack_req     = (regs_q.st == ST_IACK);
        iack_level   = regs_q.lvl;
        exc_done     = regs_q.done;
        addr_rst_req = regs_q.arr;
        halted       = (regs_q.st == ST_HALT);
    end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sr_s,
    input logic              sr_t,
    input logic [2:0]        sr_ipl,
    input logic [ADDR_W-1:0] vbr,
    input logic              vf_req,
    input logic [ADDR_W-1:0] vf_addr,
    input logic              iack_req,
    input logic [2:0]        iack_level,
    input logic              exc_done,
    input logic              addr_rst_req,
    input logic              halted
);
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!vf_req && !iack_req && !addr_rst_req)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_done |=> !exc_done); // R7

    AST_ENTRY_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
        (vf_req || iack_req) |-> (sr_s && !sr_t)); // R4

    AST_FETCH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        vf_req |-> (vf_addr[1:0] == vbr[1:0])); // R3

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vf_req && iack_req)); // R6

    AST_IACK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        iack_req |-> (iack_level == sr_ipl)); // R5

    AST_ARR_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
        addr_rst_req |-> (sr_ipl == 3'b111 && vbr == '0 && vf_req && !halted)); // R8

    AST_ARR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_rst_req |=> !addr_rst_req); // R8
endmodule

bind exc_seq exc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sr_s         (sr_s),
    .sr_t         (sr_t),
    .sr_ipl       (sr_ipl),
    .vbr          (vbr),
    .vf_req       (vf_req),
    .vf_addr      (vf_addr),
    .iack_req     (iack_req),
    .iack_level   (iack_level),
    .exc_done     (exc_done),
    .addr_rst_req (addr_rst_req),
    .halted       (halted)
);

// File: tb/exc_seq_test.sv
module exc_seq_test;
    localparam int ADDR_W = 32;
    localparam int VEC_W  = 8;
    localparam int MEM_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_fof_halt = 1'b0;
    logic              cfg_iack_en = 1'b0;
    logic              flt_addr = 1'b0;
    logic              flt_illegal = 1'b0;
    logic              flt_unsup = 1'b0;
    logic              irq_req = 1'b0;
    logic [2:0]        irq_level = '0;
    logic [VEC_W-1:0]  irq_vec = '0;
    logic              iack_ack = 1'b0;
    logic [VEC_W-1:0]  iack_vec = '0;
    logic              fetch_ack = 1'b0;
    logic              sr_we = 1'b0;
    logic [5:0]        sr_wdata = '0;
    logic              vbr_we = 1'b0;
    logic [ADDR_W-1:0] vbr_wdata = '0;
    logic              mem_we = 1'b0;
    logic [MEM_W-1:0]  mem_wdata = '0;

    logic              sr_s, sr_t, sr_m;
    logic [2:0]        sr_ipl;
    logic [ADDR_W-1:0] vbr;
    logic [MEM_W-1:0]  mem_en;
    logic              vf_req;
    logic [VEC_W-1:0]  vf_vector;
    logic [ADDR_W-1:0] vf_addr;
    logic              iack_req;
    logic [2:0]        iack_level;
    logic              exc_done, addr_rst_req, halted;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    exc_seq #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .MEM_W(MEM_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_fof_halt(cfg_fof_halt), .cfg_iack_en(cfg_iack_en),
        .flt_addr(flt_addr), .flt_illegal(flt_illegal), .flt_unsup(flt_unsup),
        .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec),
        .iack_ack(iack_ack), .iack_vec(iack_vec), .fetch_ack(fetch_ack),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .vbr_we(vbr_we), .vbr_wdata(vbr_wdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata),
        .sr_s(sr_s), .sr_t(sr_t), .sr_m(sr_m), .sr_ipl(sr_ipl), .vbr(vbr), .mem_en(mem_en),
        .vf_req(vf_req), .vf_vector(vf_vector), .vf_addr(vf_addr),
        .iack_req(iack_req), .iack_level(iack_level), .exc_done(exc_done),
        .addr_rst_req(addr_rst_req), .halted(halted)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_reset_vals(input string req);
        chk(req, "sr_s", 32'(sr_s), 1);
        chk(req, "sr_t", 32'(sr_t), 0);
        chk(req, "sr_m", 32'(sr_m), 0);
        chk(req, "sr_ipl", 32'(sr_ipl), 7);
        chk(req, "vbr", vbr, 0);
        chk(req, "mem_en", 32'(mem_en), 0);
        chk(req, "halted", 32'(halted), 0);
        chk(req, "vf_req", 32'(vf_req), 1);
        chk(req, "vf_vector", 32'(vf_vector), 0);
        chk(req, "vf_addr", vf_addr, 0);
    endtask

    task automatic ack_fetch();
        fetch_ack = 1'b1;
        tick();
        fetch_ack = 1'b0;
        chk("R7", "exc_done after fetch", 32'(exc_done), 1);
        chk("R2", "vf_req after fetch", 32'(vf_req), 0);
    endtask

    task automatic write_sr(input logic [5:0] v);
        sr_we = 1'b1; sr_wdata = v;
        tick();
        sr_we = 1'b0;
    endtask

    task automatic write_vbr(input logic [31:0] v);
        vbr_we = 1'b1; vbr_wdata = v;
        tick();
        vbr_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        ack_fetch();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] bases [4];
        bases[0] = 32'h0000_0000;
        bases[1] = 32'h0000_0100;
        bases[2] = 32'hFFFF_FF00;
        bases[3] = 32'h1234_5670;

        // R1: values held in reset and on the first cycle after release
        tick();
        check_reset_vals("R1");
        rst_n = 1'b1;
        tick();
        check_reset_vals("R1");
        chk("R1", "exc_done", 32'(exc_done), 0);
        // R2: reset fetch completes
        ack_fetch();
        tick();
        chk("R7", "exc_done one cycle", 32'(exc_done), 0);

        // R3/R4: fault priority sweep over bases, with and without interrupt
        for (int b = 0; b < 4; b++) begin
            for (int fm = 1; fm < 8; fm++) begin
                for (int wi = 0; wi < 2; wi++) begin
                    logic [31:0] ev;
                    write_vbr(bases[b]);
                    write_sr(6'b011_011);
                    flt_addr = fm[2]; flt_illegal = fm[1]; flt_unsup = fm[0];
                    irq_req = wi[0]; irq_level = 3'd7; irq_vec = 8'h55;
                    tick();
                    flt_addr = 0; flt_illegal = 0; flt_unsup = 0; irq_req = 0;
                    ev = fm[2] ? 32'd3 : (fm[1] ? 32'd4 : 32'd61);
                    chk("R3", "vf_req", 32'(vf_req), 1);
                    chk("R3", "vf_vector", 32'(vf_vector), ev);
                    chk("R3", "vf_addr", vf_addr, bases[b] + 4 * ev);
                    chk("R3", "iack_req", 32'(iack_req), 0);
                    chk("R4", "sr_s", 32'(sr_s), 1);
                    chk("R4", "sr_t", 32'(sr_t), 0);
                    chk("R4", "sr_m", 32'(sr_m), 1);
                    chk("R4", "sr_ipl", 32'(sr_ipl), 3);
                    chk("R7", "no reset req", 32'(addr_rst_req), 0);
                    ack_fetch();
                end
            end
        end

        // R5/R6: all mask/level pairs in both vector-source modes
        write_vbr(32'h0000_2000);
        for (int ie = 0; ie < 2; ie++) begin
            cfg_iack_en = ie[0];
            for (int mk = 0; mk < 8; mk++) begin
                for (int lv = 0; lv < 8; lv++) begin
                    bit take;
                    logic [31:0] ev;
                    write_sr({3'b100, 3'(mk)});
                    irq_req = 1'b1; irq_level = 3'(lv); irq_vec = 8'(8'h40 + lv);
                    tick();
                    irq_req = 1'b0;
                    take = (lv > mk) || (lv == 7);
                    if (take) begin
                        chk("R5", "mask raised", 32'(sr_ipl), 32'(lv));
                        chk("R4", "sr_s irq", 32'(sr_s), 1);
                        if (ie == 1) begin
                            chk("R6", "iack_req", 32'(iack_req), 1);
                            chk("R6", "iack_level", 32'(iack_level), 32'(lv));
                            chk("R6", "no fetch yet", 32'(vf_req), 0);
                            iack_ack = 1'b1; iack_vec = 8'(8'h80 + lv);
                            tick();
                            iack_ack = 1'b0;
                            ev = 32'h80 + lv;
                        end else begin
                            ev = 32'h40 + lv;
                        end
                        chk("R6", "vf_req", 32'(vf_req), 1);
                        chk("R6", "vf_vector", 32'(vf_vector), ev);
                        chk("R3", "irq vf_addr", vf_addr, 32'h2000 + 4 * ev);
                        ack_fetch();
                    end else begin
                        chk("R5", "not taken vf", 32'(vf_req), 0);
                        chk("R5", "not taken iack", 32'(iack_req), 0);
                        chk("R5", "mask kept", 32'(sr_ipl), 32'(mk));
                    end
                end
            end
        end
        cfg_iack_en = 1'b0;

        // R10: writes in run, ignored with exception and during entry
        mem_we = 1'b1; mem_wdata = 2'b11;
        tick();
        mem_we = 1'b0;
        chk("R10", "mem write", 32'(mem_en), 3);
        write_sr(6'b100_010);
        chk("R10", "sr write ipl", 32'(sr_ipl), 2);
        flt_illegal = 1'b1; sr_we = 1'b1; sr_wdata = 6'b011_101;
        vbr_we = 1'b1; vbr_wdata = 32'hDEAD_0000;
        tick();
        flt_illegal = 1'b0; sr_we = 1'b0; vbr_we = 1'b0;
        chk("R10", "m kept", 32'(sr_m), 0);
        chk("R10", "ipl kept", 32'(sr_ipl), 2);
        chk("R10", "vbr kept", vbr, 32'h2000);
        vbr_we = 1'b1; vbr_wdata = 32'hBEEF_0000; mem_we = 1'b1; mem_wdata = 2'b00;
        sr_we = 1'b1; sr_wdata = 6'b011_000;
        tick();
        vbr_we = 1'b0; mem_we = 1'b0; sr_we = 1'b0;
        chk("R10", "vbr in entry", vbr, 32'h2000);
        chk("R10", "mem in entry", 32'(mem_en), 3);
        chk("R10", "ipl in entry", 32'(sr_ipl), 2);
        ack_fetch();

        // R8: fault during vector fetch with reset option
        cfg_fof_halt = 1'b0;
        flt_illegal = 1'b1;
        tick();
        flt_illegal = 1'b0;
        flt_addr = 1'b1;
        tick();
        flt_addr = 1'b0;
        chk("R8", "addr_rst_req", 32'(addr_rst_req), 1);
        check_reset_vals("R8");
        tick();
        chk("R8", "reset req pulse", 32'(addr_rst_req), 0);
        chk("R8", "still reset fetch", 32'(vf_req), 1);
        // R8: fault during reset fetch
        flt_unsup = 1'b1;
        tick();
        flt_unsup = 1'b0;
        chk("R8", "fof in reset fetch", 32'(addr_rst_req), 1);
        ack_fetch();
        // R8: fault during acknowledge wait
        cfg_iack_en = 1'b1;
        irq_req = 1'b1; irq_level = 3'd7;
        tick();
        irq_req = 1'b0;
        chk("R6", "iack entered", 32'(iack_req), 1);
        flt_addr = 1'b1;
        tick();
        flt_addr = 1'b0;
        chk("R8", "fof in iack", 32'(addr_rst_req), 1);
        chk("R8", "iack dropped", 32'(iack_req), 0);
        ack_fetch();

        // R7: fault after done is ordinary
        flt_unsup = 1'b1;
        tick();
        flt_unsup = 1'b0;
        chk("R7", "ordinary fault vec", 32'(vf_vector), 61);
        chk("R7", "ordinary no rst", 32'(addr_rst_req), 0);
        chk("R7", "ordinary not halted", 32'(halted), 0);

        // R11: async reset aborts a vector fetch
        write_vbr(32'h0);
        #3 rst_n = 1'b0;
        #1;
        check_reset_vals("R11");
        tick();
        do_reset();

        // R9: halt on fault in acknowledge wait, inputs ignored
        cfg_fof_halt = 1'b1;
        write_vbr(32'h0000_4000);
        irq_req = 1'b1; irq_level = 3'd7;
        tick();
        irq_req = 1'b0;
        flt_unsup = 1'b1;
        tick();
        flt_unsup = 1'b0;
        chk("R9", "halted", 32'(halted), 1);
        chk("R9", "iack dropped", 32'(iack_req), 0);
        chk("R9", "no fetch", 32'(vf_req), 0);
        chk("R9", "no reset req", 32'(addr_rst_req), 0);
        for (int k = 0; k < 3; k++) begin
            fetch_ack = 1; iack_ack = 1; flt_addr = 1; irq_req = 1;
            sr_we = 1; sr_wdata = 6'b010_001; vbr_we = 1; vbr_wdata = 32'h9999_0000;
            mem_we = 1; mem_wdata = 2'b11;
            tick();
        end
        fetch_ack = 0; iack_ack = 0; flt_addr = 0; irq_req = 0;
        sr_we = 0; vbr_we = 0; mem_we = 0;
        chk("R9", "halt sticky", 32'(halted), 1);
        chk("R9", "ipl frozen", 32'(sr_ipl), 7);
        chk("R9", "t frozen", 32'(sr_t), 0);
        chk("R9", "vbr frozen", vbr, 32'h4000);
        chk("R9", "mem frozen", 32'(mem_en), 0);
        chk("R9", "done quiet", 32'(exc_done), 0);

        // R11: reset leaves halt
        #3 rst_n = 1'b0;
        #1;
        check_reset_vals("R11");
        tick();
        rst_n = 1'b1;
        tick();

        // R9: halt on fault during reset fetch
        flt_addr = 1'b1;
        tick();
        flt_addr = 1'b0;
        chk("R9", "halt in reset fetch", 32'(halted), 1);
        chk("R9", "halt no fetch", 32'(vf_req), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule